// File: doc/BRIEF.md
# Split-Transaction Timeout Timer

This block holds the two programmable words that set how long a requester waits for the response half of a split transaction, and it times that wait. The seconds word carries whole seconds in its three lowest bits. The fraction word carries a fraction of a second in its thirteen highest bits, counted in 125 µs cycles. Both words are combined into a single wait length, measured in 125 µs ticks. That length is never allowed to fall below 800 ticks (100 ms).

A requester pulses `tmr_start` when it sends a request that will be answered later. The block then counts down one step on every `cyc_tick` pulse and raises `tmr_expired` for one clock when the wait has run out. If the response arrives first, the requester pulses `tmr_cancel`. Software-visible writes to the two words take effect on the next start and do not disturb a countdown that is already running.

Top module: `split_timeout_timer`

## Requirements
- R1: The seconds word (`reg_sel` = 0) stores only bits 2:0 of a write; `rd_seconds` shows those bits, and bits 31:3 always read as zero.
- R2: The fraction word (`reg_sel` = 1) stores only bits 31:19 of a write; `rd_fraction` shows those bits, and bits 18:0 always read as zero. A write to one word leaves the other unchanged.
- R3: After reset, `rd_seconds` = 0 and `rd_fraction` = 800 << 19 (32'h1900_0000), which is a 100 ms wait.
- R4: The wait length in ticks is seconds × 8000 + (fraction >> 19).
- R5: A wait length below 800 ticks is raised to 800 ticks.
- R6: A write to either word changes the wait length used by any start in a later cycle.
- R7: After `tmr_start`, `tmr_expired` is high for exactly one clock, in the clock after the N-th `cyc_tick` pulse, where N is the wait length. Ticks in the start cycle are not counted.
- R8: `tmr_cancel` stops a running countdown, and no expiry follows it. If start and cancel arrive in the same cycle, start wins.
- R9: A start during a countdown reloads the full wait length.
- R10: A register write during a countdown does not change the remaining count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | Word select: 0 = seconds, 1 = fraction |
| reg_wdata | input | 32 | Write data |
| rd_seconds | output | 32 | Current seconds word |
| rd_fraction | output | 32 | Current fraction word |
| cyc_tick | input | 1 | One-clock pulse every 125 µs |
| tmr_start | input | 1 | Load the wait length and start the countdown |
| tmr_cancel | input | 1 | Stop the countdown without expiry |
| tmr_expired | output | 1 | One-clock pulse when the countdown reaches zero |

## Verification
The assertions check four properties on every cycle:
- the zero bits of both read words;
- the 800-tick floor on the wait length;
- that the expiry output is a single-cycle pulse and never follows a cancel;
- that the count stays unchanged in any cycle without a tick or a start, including cycles with register writes.

The exact tick count up to expiry under different settings can only be shown by the bench's scenarios. The same holds for the reload on a second start, the cancel that suppresses expiry, and the rule that a write made mid-count applies only to the next start.

// File: rtl/split_timeout_pkg.sv
// Shared definitions for the split-transaction timeout timer.
// Assumes a 32-bit register data path.
package split_timeout_pkg;

    localparam int unsigned REG_W = 32;

    // Register word selector.
    typedef enum logic {
        SEL_SECONDS  = 1'b0,
        SEL_FRACTION = 1'b1
    } word_sel_e;

endpackage

// File: rtl/split_timeout_regs.sv
// Holds the seconds and fraction words. Unused bits are not stored and
// read back as zero. Assumes one write at most per cycle.
module split_timeout_regs
    import split_timeout_pkg::*;
#(
    parameter int unsigned SEC_W      = 3,
    parameter int unsigned FRAC_W     = 13,
    parameter int unsigned FRAC_RESET = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [SEC_W-1:0]  seconds,
    output logic [FRAC_W-1:0] fraction,
    output logic [REG_W-1:0]  rd_seconds,
    output logic [REG_W-1:0]  rd_fraction
);
    localparam int unsigned FRAC_LSB = REG_W - FRAC_W;

    logic [SEC_W-1:0]  sec_q;
    logic [FRAC_W-1:0] frac_q;

    // Capture the kept bits of a write into the selected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            frac_q <= FRAC_W'(FRAC_RESET);
        end else if (wr) begin
            if (word_sel_e'(sel) == SEL_SECONDS) begin
                sec_q <= wdata[SEC_W-1:0];
            end else begin
                frac_q <= wdata[REG_W-1:FRAC_LSB];
            end
        end
    end

    // Place the stored fields at their bit positions in the read words.
    always_comb begin
        rd_seconds  = '0;
        rd_fraction = '0;
        rd_seconds[SEC_W-1:0]           = sec_q;
        rd_fraction[REG_W-1:FRAC_LSB]   = frac_q;
    end

    assign seconds  = sec_q;
    assign fraction = frac_q;

endmodule

// File: rtl/split_timeout_expiry.sv
// Turns the seconds and fraction fields into a wait length in ticks and
// applies the lower floor. Purely combinational; the multiply is by a
// constant, so it reduces to a few shifted adds.
module split_timeout_expiry #(
    parameter int unsigned SEC_W         = 3,
    parameter int unsigned FRAC_W        = 13,
    parameter int unsigned TICKS_PER_SEC = 8000,
    parameter int unsigned FLOOR_TICKS   = 800,
    parameter int unsigned CNT_W         = 16
) (
    input  logic [SEC_W-1:0]  seconds,
    input  logic [FRAC_W-1:0] fraction,
    output logic [CNT_W-1:0]  wait_ticks
);
    logic [CNT_W-1:0] raw_ticks;

    // Combine the fields and raise short settings to the floor.
    always_comb begin
        raw_ticks = CNT_W'(seconds) * CNT_W'(TICKS_PER_SEC) + CNT_W'(fraction);
        if (raw_ticks < CNT_W'(FLOOR_TICKS)) begin
            wait_ticks = CNT_W'(FLOOR_TICKS);
        end else begin
            wait_ticks = raw_ticks;
        end
    end

endmodule

// File: rtl/split_timeout_countdown.sv
// Countdown timer. Start loads the wait length (start beats cancel),
// each tick while running steps down, and a one-clock expiry pulse
// follows the step that reaches zero. Assumes load_ticks >= 1.
module split_timeout_countdown #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cancel,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_ticks,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;

    // Load, stop or step the counter and emit the expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (start) begin
                run_q <= 1'b1;
                cnt_q <= load_ticks;
            end else if (cancel) begin
                run_q <= 1'b0;
            end else if (run_q && tick) begin
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    cnt_q <= '0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign running = run_q;
    assign count   = cnt_q;
    assign expired = exp_q;

endmodule

// File: rtl/split_timeout_timer.sv
// Top level: programmable split-transaction timeout words plus the
// countdown that times one outstanding request. Assumes cyc_tick is a
// single-clock pulse every 125 us.
module split_timeout_timer
    import split_timeout_pkg::*;
#(
    parameter int unsigned SEC_W         = 3,
    parameter int unsigned FRAC_W        = 13,
    parameter int unsigned TICKS_PER_SEC = 8000,
    parameter int unsigned FLOOR_TICKS   = 800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] rd_seconds,
    output logic [31:0] rd_fraction,
    input  logic        cyc_tick,
    input  logic        tmr_start,
    input  logic        tmr_cancel,
    output logic        tmr_expired
);
    localparam int unsigned MAX_TICKS =
        ((1 << SEC_W) - 1) * TICKS_PER_SEC + ((1 << FRAC_W) - 1);
    localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

    logic [SEC_W-1:0]  seconds;
    logic [FRAC_W-1:0] fraction;
    logic [CNT_W-1:0]  wait_ticks;
    logic              running;
    logic [CNT_W-1:0]  count;

    split_timeout_regs #(
        .SEC_W      (SEC_W),
        .FRAC_W     (FRAC_W),
        .FRAC_RESET (FLOOR_TICKS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .sel         (reg_sel),
        .wdata       (reg_wdata),
        .seconds     (seconds),
        .fraction    (fraction),
        .rd_seconds  (rd_seconds),
        .rd_fraction (rd_fraction)
    );

    split_timeout_expiry #(
        .SEC_W         (SEC_W),
        .FRAC_W        (FRAC_W),
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .FLOOR_TICKS   (FLOOR_TICKS),
        .CNT_W         (CNT_W)
    ) u_expiry (
        .seconds    (seconds),
        .fraction   (fraction),
        .wait_ticks (wait_ticks)
    );

    split_timeout_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tmr_start),
        .cancel     (tmr_cancel),
        .tick       (cyc_tick),
        .load_ticks (wait_ticks),
        .running    (running),
        .count      (count),
        .expired    (tmr_expired)
    );

endmodule

// File: rtl/split_timeout_checker.sv
// Cycle-by-cycle properties of the split timeout timer, bound to the top.
module split_timeout_checker #(
    parameter int unsigned SEC_W       = 3,
    parameter int unsigned FRAC_W      = 13,
    parameter int unsigned FLOOR_TICKS = 800,
    parameter int unsigned CNT_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      rd_seconds,
    input logic [31:0]      rd_fraction,
    input logic             cyc_tick,
    input logic             tmr_start,
    input logic             tmr_cancel,
    input logic             tmr_expired,
    input logic [CNT_W-1:0] wait_ticks,
    input logic             running,
    input logic [CNT_W-1:0] count
);
    localparam int unsigned FRAC_LSB = 32 - FRAC_W;

    a_r1_sec_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_seconds[31:SEC_W] == '0);

    a_r2_frac_lower_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fraction[FRAC_LSB-1:0] == '0);

    a_r5_floor_held: assert property (@(posedge clk) disable iff (!rst_n)
        wait_ticks >= CNT_W'(FLOOR_TICKS));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expired |=> !tmr_expired);

    a_r8_no_expiry_after_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cancel && !tmr_start) |=> !tmr_expired);

    a_r10_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cyc_tick && !tmr_start && !tmr_cancel) |=> $stable(count));

endmodule

bind split_timeout_timer split_timeout_checker #(
    .SEC_W       (SEC_W),
    .FRAC_W      (FRAC_W),
    .FLOOR_TICKS (FLOOR_TICKS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_seconds  (rd_seconds),
    .rd_fraction (rd_fraction),
    .cyc_tick    (cyc_tick),
    .tmr_start   (tmr_start),
    .tmr_cancel  (tmr_cancel),
    .tmr_expired (tmr_expired),
    .wait_ticks  (wait_ticks),
    .running     (running),
    .count       (count)
);

// File: tb/split_timeout_timer_test.sv
// Bench for the split timeout timer: directed corners plus seeded random.
module split_timeout_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_seconds;
    logic [31:0] rd_fraction;
    logic        cyc_tick = 1'b0;
    logic        tmr_start = 1'b0;
    logic        tmr_cancel = 1'b0;
    logic        tmr_expired;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] sh_sec = 32'd0;
    logic [31:0] sh_frac = 32'h1900_0000;

    always #10 clk = ~clk;   // 50 MHz

    split_timeout_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .rd_seconds  (rd_seconds),
        .rd_fraction (rd_fraction),
        .cyc_tick    (cyc_tick),
        .tmr_start   (tmr_start),
        .tmr_cancel  (tmr_cancel),
        .tmr_expired (tmr_expired)
    );

    function automatic int exp_wait(input logic [31:0] s, input logic [31:0] f);
        int t;
        t = int'(s & 32'h7) * 8000 + int'(f >> 19);
        return (t < 800) ? 800 : t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    task automatic write_word(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel) sh_frac = d & 32'hFFF8_0000;
        else     sh_sec  = d & 32'h0000_0007;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        tmr_start = 1'b1; cyc_tick = 1'b0;
        @(negedge clk);
        tmr_start = 1'b0;
    endtask

    // Tick every cycle after a start; return ticks counted up to expiry.
    task automatic run_ticks(input int limit, output int n);
        n = 0;
        cyc_tick = 1'b1;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (tmr_expired) break;
        end
        cyc_tick = 1'b0;
    endtask

    task automatic timed_case(input string req, input logic [31:0] s, input logic [31:0] f);
        int n;
        write_word(1'b0, s);
        write_word(1'b1, f);
        pulse_start();
        run_ticks(70000, n);
        check(req, n, exp_wait(sh_sec, sh_frac));
        @(negedge clk);
        check({req, " pulse width"}, {31'd0, tmr_expired}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int n;
        logic [31:0] d;
        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset values
        check("R3 seconds reset", rd_seconds, 32'd0);
        check("R3 fraction reset", rd_fraction, 32'h1900_0000);

        // R1 / R2 masking with random data
        for (int i = 0; i < 16; i++) begin
            d = $urandom();
            write_word(1'b0, d);
            check("R1 seconds mask", rd_seconds, d & 32'h7);
            check("R2 fraction untouched", rd_fraction, sh_frac);
            d = $urandom();
            write_word(1'b1, d);
            check("R2 fraction mask", rd_fraction, d & 32'hFFF8_0000);
            check("R1 seconds untouched", rd_seconds, sh_sec);
        end

        // R7 R5 reset wait length is the floor
        write_word(1'b0, 32'd0);
        write_word(1'b1, 32'h1900_0000);
        pulse_start();
        run_ticks(70000, n);
        check("R7 default wait", n, 32'd800);

        // R5 floor clamp
        timed_case("R5 clamp zero", 32'd0, 32'd0);
        timed_case("R5 clamp 799", 32'd0, 32'd799 << 19);
        // R4 conversion corners
        timed_case("R4 fraction 1000", 32'd0, 32'd1000 << 19);
        timed_case("R4 fraction max", 32'd0, 32'hFFFF_FFFF);
        timed_case("R4 one second", 32'hFFFF_FFF9, 32'h0007_FFFF);
        timed_case("R4 maximum", 32'd7, 32'hFFF8_0000);
        for (int i = 0; i < 4; i++) begin
            timed_case("R4 random", $urandom() & 32'h1, $urandom());
        end

        // R6 new value used by start right after write
        write_word(1'b0, 32'd0);
        write_word(1'b1, 32'd1200 << 19);
        pulse_start();
        run_ticks(70000, n);
        check("R6 write then start", n, 32'd1200);

        // R10 write mid-count leaves the count alone
        write_word(1'b1, 32'd1000 << 19);
        pulse_start();
        cyc_tick = 1'b1;
        repeat (300) @(negedge clk);
        cyc_tick = 1'b0;
        write_word(1'b0, 32'd1);
        write_word(1'b1, 32'd900 << 19);
        run_ticks(70000, n);
        check("R10 mid-count write", n + 300, 32'd1000);
        pulse_start();
        run_ticks(70000, n);
        check("R6 next start uses new value", n, 32'd8900);

        // R9 restart reloads
        write_word(1'b0, 32'd0);
        write_word(1'b1, 32'd850 << 19);
        pulse_start();
        cyc_tick = 1'b1;
        repeat (500) @(negedge clk);
        pulse_start();
        run_ticks(70000, n);
        check("R9 reload on restart", n, 32'd850);

        // R8 cancel suppresses expiry
        pulse_start();
        cyc_tick = 1'b1;
        repeat (400) @(negedge clk);
        tmr_cancel = 1'b1;
        @(negedge clk);
        tmr_cancel = 1'b0;
        n = 0;
        repeat (1000) begin
            @(negedge clk);
            if (tmr_expired) n++;
        end
        cyc_tick = 1'b0;
        check("R8 no expiry after cancel", n, 32'd0);

        // R8 start and cancel together: start wins
        @(negedge clk);
        tmr_start = 1'b1; tmr_cancel = 1'b1;
        @(negedge clk);
        tmr_start = 1'b0; tmr_cancel = 1'b0;
        run_ticks(70000, n);
        check("R8 start beats cancel", n, 32'd850);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule